// File: doc/BRIEF.md
# Write-Cycle Status Read Reporter

This block sits in the read path of a byte-wide non-volatile memory that has a page-buffered internal write. A write sequencer beside it reports two things: whether the page-load window is still open (its timer is running) and whether the internal programming cycle is busy. While either is true, a bus read returns three status bits in place of array data. These tell the host whether programming has finished and whether more bytes may still be loaded. When the memory is idle, reads pass array data through unchanged. Pad tri-stating is modelled as a per-bit output-enable vector.

A three-state machine follows the write sequencer. READY is the idle state. LOAD means the page-load timer is running. PROG means the internal cycle is busy. The transitions are as follows. go_prog (READY or LOAD to PROG) is taken whenever busy is high. go_load (READY to LOAD) is taken when the timer runs and busy is low. abort_load (LOAD to READY) is taken when both inputs are low. finish (PROG to READY) is taken when busy falls. The status values are captured once, at the first cycle of each read, and held for the rest of that read. As a result, every read advances the toggle bit exactly once, however long the read lasts.

Top module: `wr_status_rpt`

## Requirements
- R1: When no read is active, dq_oe is all zeros and dq_out is zero on the next clock. A read is active when ce_n=0, oe_n=0 and we_n=1; ce_n high, oe_n high or we_n low each block it.
- R2: A read that starts in READY drives dq_oe all ones, and dq_out follows array_data with one clock of delay for as long as the read lasts.
- R3: A read that starts in LOAD or PROG drives only bits 7, 6 and 5 (dq_oe = 8'hE0). Bits 4 to 0 are not driven and read zero on dq_out.
- R4: During a status read, dq_out bit 7 is the inverse of last_byte bit 7, taken at the start of the read.
- R5: During a status read, dq_out bit 6 is a toggle. It is cleared in READY, so the first status read after leaving READY returns 0, and each following status read returns the opposite value.
- R6: During a status read, dq_out bit 5 is 0 if the read starts in LOAD and 1 if it starts in PROG.
- R7: All outputs of a status read are fixed at its first cycle and remain stable while the read continues. This holds even if last_byte or the phase changes during the read.
- R8: Phase transitions follow the brief: busy high forces PROG from any state, including when the timer is also running. The timer running with busy low moves READY to LOAD. Both inputs low return LOAD or PROG to READY.
- R9: Once busy has fallen, reads return array data again, including the true bit 7. The next programming cycle starts its toggle from 0.
- R10: After reset the phase is READY and no output bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low (high for a read) |
| busy | input | 1 | Internal programming cycle in progress |
| timer_run | input | 1 | Page-load timer running |
| last_byte | input | DATA_W | Last byte latched by the write path |
| array_data | input | DATA_W | Data read from the array |
| dq_out | output | DATA_W | Read data toward the pads |
| dq_oe | output | DATA_W | Per-bit pad drive enable |

## Verification
The bench builds the block with DATA_W = 8. With this width the three status bits sit at 7, 6 and 5, and a five-bit undriven field below them lets the mask check of R3 show. The 8-bit data and last-byte values let both polarities of bit 7 be tried against the inverse rule. Directed phases cover each transition, long reads with changing inputs, and a new cycle entered straight from READY. A long random run then mixes read strobes with sequencer changes.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_LOAD  = 2'd1,
        PH_PROG  = 2'd2
    } phase_t;

    localparam int STAT_BITS = 3;
endpackage

// File: rtl/wsr_phase_fsm.sv
module wsr_phase_fsm
    import wsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   busy,
    input  logic   timer_run,
    output phase_t phase
);
    phase_t nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_READY: begin
                if (busy)           nxt = PH_PROG;
                else if (timer_run) nxt = PH_LOAD;
            end
            PH_LOAD: begin
                if (busy)            nxt = PH_PROG;
                else if (!timer_run) nxt = PH_READY;
            end
            PH_PROG: begin
                if (!busy) nxt = PH_READY;
            end
            default: nxt = PH_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_READY;
        else        phase <= nxt;
    end
endmodule

// File: rtl/wsr_read_detect.sv
module wsr_read_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_now,
    output logic rd_start
);
    logic rd_prev;

    assign rd_now   = !ce_n && !oe_n && we_n;
    assign rd_start = rd_now && !rd_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_now;
    end
endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              rd_now,
    input  logic              rd_start,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    localparam int LOW_W = DATA_W - STAT_BITS;

    logic [DATA_W-1:0]    stat_mask;
    logic                 tog;
    logic                 snap_stat;
    logic [STAT_BITS-1:0] snap_bits;
    logic                 live_stat;
    logic [STAT_BITS-1:0] live_bits;
    logic                 use_stat;
    logic [STAT_BITS-1:0] use_bits;

    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign stat_mask[b] = (b >= LOW_W);
    end

    always_comb begin
        live_stat = (phase != PH_READY);
        live_bits = {~last_msb, tog, (phase == PH_PROG)};
        use_stat  = rd_start ? live_stat : snap_stat;
        use_bits  = rd_start ? live_bits : snap_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog       <= 1'b0;
            snap_stat <= 1'b0;
            snap_bits <= '0;
            dq_out    <= '0;
            dq_oe     <= '0;
        end else begin
            if (rd_start) begin
                snap_stat <= live_stat;
                snap_bits <= live_bits;
            end
            if (phase == PH_READY) tog <= 1'b0;
            else if (rd_start)     tog <= ~tog;

            if (!rd_now) begin
                dq_oe  <= '0;
                dq_out <= '0;
            end else if (use_stat) begin
                dq_oe  <= stat_mask;
                dq_out <= {use_bits, {LOW_W{1'b0}}};
            end else begin
                dq_oe  <= '1;
                dq_out <= array_data;
            end
        end
    end
endmodule

// File: rtl/wr_status_rpt.sv
module wr_status_rpt
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic              timer_run,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    phase_t phase;
    logic   rd_now;
    logic   rd_start;

    wsr_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .timer_run (timer_run),
        .phase     (phase)
    );

    wsr_read_detect u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rd_now   (rd_now),
        .rd_start (rd_start)
    );

    wsr_status_mux #(.DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .rd_now     (rd_now),
        .rd_start   (rd_start),
        .last_msb   (last_byte[DATA_W-1]),
        .array_data (array_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );
endmodule

// File: rtl/wsr_checker.sv
module wsr_checker
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic [DATA_W-1:0] last_byte,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] dq_out,
    input logic [DATA_W-1:0] dq_oe,
    input phase_t            phase
);
    localparam logic [DATA_W-1:0] MASK = {{STAT_BITS{1'b1}}, {(DATA_W-STAT_BITS){1'b0}}};

    logic rd_c;
    logic rd_q;
    logic st_c;

    assign rd_c = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_c;
    end

    assign st_c = rd_c && !rd_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c |=> (dq_oe == '0 && dq_out == '0));

    assert_ready_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_c && phase == PH_READY) |=> (dq_oe == '1 && dq_out == $past(array_data)));

    assert_status_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0 && dq_oe != '1) |-> (dq_oe == MASK && (dq_out & ~MASK) == '0));

    assert_poll_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_c && phase != PH_READY) |=> (dq_out[DATA_W-1] == !$past(last_byte[DATA_W-1])));

    assert_timer_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_c && phase != PH_READY) |=> (dq_out[DATA_W-3] == ($past(phase) == PH_PROG)));

    assert_hold_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && dq_oe == MASK) |=> ($stable(dq_out) && dq_oe == MASK));

    assert_busy_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (phase == PH_PROG));
endmodule

bind wr_status_rpt wsr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .busy       (busy),
    .last_byte  (last_byte),
    .array_data (array_data),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .phase      (phase)
);

// File: tb/tb_wr_status_rpt.sv
module tb_wr_status_rpt;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic         busy = 1'b0, timer_run = 1'b0;
    logic [W-1:0] last_byte = '0, array_data = '0;
    logic [W-1:0] dq_out, dq_oe;

    int    compared = 0, mismatched = 0, cycles = 0;
    string cur_req = "R10";
    bit    seen_edge = 0;
    bit    done = 0;

    // reference model state
    int       m_ph = 0;            // 0 ready, 1 load, 2 prog
    bit       m_tog = 0, m_prev = 0, m_sst = 0;
    bit [2:0] m_sb = 0;
    bit [W-1:0] e_oe = 0, e_dq = 0;

    wr_status_rpt #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .timer_run(timer_run), .last_byte(last_byte),
        .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        seen_edge = 1;
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_tog = 0; m_prev = 0; m_sst = 0; m_sb = 0;
            e_oe = 0; e_dq = 0;
        end else begin
            bit rd, st, use_s;
            bit [2:0] bits;
            rd = !ce_n && !oe_n && we_n;
            st = rd && !m_prev;
            if (st) begin
                m_sst = (m_ph != 0);
                m_sb  = {~last_byte[W-1], m_tog, (m_ph == 2)};
            end
            use_s = m_sst;
            bits  = m_sb;
            if (!rd) begin
                e_oe = 0; e_dq = 0;
            end else if (use_s) begin
                e_oe = 8'hE0; e_dq = {bits, 5'b0};
            end else begin
                e_oe = 8'hFF; e_dq = array_data;
            end
            if (m_ph == 0) m_tog = 0;
            else if (st)   m_tog = ~m_tog;
            case (m_ph)
                0: m_ph = busy ? 2 : (timer_run ? 1 : 0);
                1: m_ph = busy ? 2 : (timer_run ? 1 : 0);
                default: m_ph = busy ? 2 : 0;
            endcase
            m_prev = rd;
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            compared++;
            if (dq_oe !== e_oe || dq_out !== e_dq) begin
                mismatched++;
                $display("FAIL %s: oe=%h dq=%h expected oe=%h dq=%h at cycle %0d",
                         cur_req, dq_oe, dq_out, e_oe, e_dq, cycles);
            end
        end
    end

    always @(negedge clk) array_data = W'($urandom);

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int n);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); oe_n = 1; ce_n = 1;
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        cur_req = "R10"; idle(3);

        // R1: blocked reads
        cur_req = "R1";
        @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1;
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0;
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
        @(negedge clk); ce_n = 1; oe_n = 1;
        idle(2);

        // R2: idle reads follow array data
        cur_req = "R2";
        rd(1); rd(4); idle(2);

        // LOAD phase: R3 R4 R5 R6
        cur_req = "R5";
        last_byte = 8'h9C;
        @(negedge clk); timer_run = 1;
        idle(2);
        rd(1); rd(2); rd(1);
        cur_req = "R4";
        last_byte = 8'h3A;
        rd(2);
        cur_req = "R6";
        rd(1);

        // PROG phase with held reads: R7
        cur_req = "R7";
        @(negedge clk); busy = 1; timer_run = 0;
        idle(2);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
        idle(2); last_byte = 8'hC5;
        idle(3);
        @(negedge clk); oe_n = 1; ce_n = 1;
        cur_req = "R3";
        rd(3); rd(1);

        // R9: end of programming
        cur_req = "R9";
        @(negedge clk); busy = 0;
        idle(2);
        rd(2);
        @(negedge clk); busy = 1;
        idle(2);
        rd(1); rd(1);
        @(negedge clk); busy = 0;
        idle(2);

        // R8: abort of load, and busy priority
        cur_req = "R8";
        @(negedge clk); timer_run = 1;
        idle(2); rd(1);
        @(negedge clk); timer_run = 0;
        idle(2); rd(1);
        @(negedge clk); timer_run = 1; busy = 1;
        idle(2); rd(2);
        @(negedge clk); busy = 0;
        idle(2); rd(1);
        @(negedge clk); timer_run = 0;
        idle(2);

        // random mix of all behaviour
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) busy = ~busy;
            if ($urandom_range(0, 11) == 0) timer_run = ~timer_run;
            if ($urandom_range(0, 7) == 0) last_byte = W'($urandom);
            ce_n = ($urandom_range(0, 5) == 0);
            oe_n = ($urandom_range(0, 2) == 0);
            we_n = ($urandom_range(0, 9) != 0);
        end
        @(negedge clk); ce_n = 1; oe_n = 1; busy = 0; timer_run = 0;
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule